// File: doc/BRIEF.md
# Trigger Prescale and Event Scaler Stage

This stage sits after the second-level processors. For every event it receives the per-trigger pass bits from the processors, thins each trigger bit with its own prescaler, and produces the prescaled bits together with a single final accept. Each trigger is set up either as a count prescaler that keeps one of every N passing events, or as a rate-limited prescaler that keeps a passing event only when a minimum number of clock cycles has gone by since that trigger last accepted.

Three event scalers follow the chain: events entering the stage, events with at least one processor pass bit, and events leaving with a final accept. The live values feed the decision summary record built alongside each output event. A snapshot strobe copies all three at the same edge into readout registers for a monitoring reader. Settings are loaded through a simple register write port, one word per trigger.

Top module: `trig_prescale_unit`

## Requirements
- R1: While rst_n is low, outValid, outBits, finalAccept, all live and snapshot scalers are zero, all prescale counters and timers are cleared, and every trigger is set to count mode with value 0.
- R2: A trigger in count mode with value N of 2 or more accepts its Nth, 2Nth, 3Nth... passing event counted since reset or the last configuration write; events without that trigger's pass bit do not advance its count.
- R3: A trigger in count mode with value 0 or 1 accepts every passing event.
- R4: A trigger in rate mode with interval I accepts a passing event when its timer is zero; an accept loads the timer with I and the timer falls by one each cycle, so after an accept at cycle k the next passing event is accepted no earlier than cycle k+I. The first passing event after reset or a configuration write is accepted.
- R5: outValid is high exactly one cycle after a cycle with evtValid high; outBits holds the prescaled bits of that event (never set for a trigger whose pass bit was low) and finalAccept equals the OR of outBits.
- R6: liveEnter counts cycles with evtValid high and livePass counts those of them with any pass bit set; all scalers are SCL_W bits wide and wrap to zero after their maximum.
- R7: liveAccept counts events leaving with finalAccept high; in the cycle outValid is high, all live scalers already include that event.
- R8: snapStrobe copies the three live scaler values held before that edge into snapEnter, snapPass and snapAccept, which then hold until the next strobe.
- R9: A write with cfgWrEn high stores cfgData into trigger cfgAddr: bit VAL_W selects rate mode (1) or count mode (0), bits VAL_W-1:0 hold N or I. Any write clears the counters and timers of all triggers but leaves the scalers untouched.
- R10: In a cycle with evtValid low, outValid and outBits are zero in the next cycle and no scaler changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Trigger index of the write |
| cfgData | input | VAL_W+1 | Mode bit on top, prescale value or interval below |
| evtValid | input | 1 | An event with processor decision is present |
| passBits | input | NUM_TRIG | Processor pass bit per trigger |
| snapStrobe | input | 1 | Copy live scalers into readout registers |
| outValid | output | 1 | Prescaled event result valid |
| outBits | output | NUM_TRIG | Prescaled trigger bits |
| finalAccept | output | 1 | OR of prescaled trigger bits |
| liveEnter | output | SCL_W | Live count of entering events |
| livePass | output | SCL_W | Live count of events with any pass bit |
| liveAccept | output | SCL_W | Live count of accepted events |
| snapEnter | output | SCL_W | Snapshot of entering count |
| snapPass | output | SCL_W | Snapshot of passing count |
| snapAccept | output | SCL_W | Snapshot of accepted count |

## Verification
Directed runs load a mix of count values 0, 1 and 3 with a rate interval on the last trigger and feed back-to-back all-pass events, which separates the Nth-event rule, the accept-all rule and the timer spacing; a repeated write mid-count shows the state clear. Random phases vary the pass patterns, gaps between events, configurations and snapshot timing, so idle cycles that must only run timers down are told apart from events that advance counters. A long run of events with a narrow scaler width drives every scaler through its wrap.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef struct packed {
    logic evt;
    logic clearState;
    logic snap;
  } pscStrobes_t;

endpackage

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int VAL_W    = 16,
  localparam int ADDR_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [VAL_W:0]            cfgData,
  input  logic                      evtValid,
  input  logic                      snapStrobe,
  output pscStrobes_t               strb,
  output logic [NUM_TRIG-1:0]       modeVec,
  output logic [NUM_TRIG*VAL_W-1:0] valVec
);

  // Strobes towards the datapath
  always_comb begin
    strb.evt        = evtValid;
    strb.clearState = cfgWrEn;
    strb.snap       = snapStrobe;
  end

  // Per-trigger settings registers
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        modeVec[t]                 <= 1'b0;
        valVec[t*VAL_W +: VAL_W]   <= '0;
      end else if (cfgWrEn && cfgAddr == ADDR_W'(t)) begin
        modeVec[t]                 <= cfgData[VAL_W];
        valVec[t*VAL_W +: VAL_W]   <= cfgData[VAL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int VAL_W    = 16,
  parameter int SCL_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pscStrobes_t               strb,
  input  logic [NUM_TRIG-1:0]       modeVec,
  input  logic [NUM_TRIG*VAL_W-1:0] valVec,
  input  logic [NUM_TRIG-1:0]       passBits,
  output logic                      outValid,
  output logic [NUM_TRIG-1:0]       outBits,
  output logic                      finalAccept,
  output logic [SCL_W-1:0]          liveEnter,
  output logic [SCL_W-1:0]          livePass,
  output logic [SCL_W-1:0]          liveAccept,
  output logic [SCL_W-1:0]          snapEnter,
  output logic [SCL_W-1:0]          snapPass,
  output logic [SCL_W-1:0]          snapAccept
);

  logic [NUM_TRIG-1:0] accBits;

  // One prescaler per trigger: count state and rate timer
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic [VAL_W-1:0] val;
    logic [VAL_W-1:0] cnt;
    logic [VAL_W-1:0] tmr;
    logic             passing;
    logic             lastOne;
    logic             expired;

    assign val     = valVec[t*VAL_W +: VAL_W];
    assign passing = strb.evt & passBits[t];
    assign lastOne = (val <= VAL_W'(1)) || (cnt == val - VAL_W'(1));
    assign expired = (tmr == '0);
    assign accBits[t] = passing & (modeVec[t] ? expired : lastOne);

    always_ff @(posedge clk) begin
      if (!rst_n || strb.clearState) begin
        cnt <= '0;
      end else if (passing && !modeVec[t]) begin
        cnt <= lastOne ? '0 : cnt + VAL_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || strb.clearState) begin
        tmr <= '0;
      end else if (accBits[t] && modeVec[t]) begin
        tmr <= val;
      end else if (!expired) begin
        tmr <= tmr - VAL_W'(1);
      end
    end
  end

  // Registered event result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outBits     <= '0;
      finalAccept <= 1'b0;
    end else begin
      outValid    <= strb.evt;
      outBits     <= strb.evt ? accBits : '0;
      finalAccept <= strb.evt & (|accBits);
    end
  end

  // Event scalers, wrapping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveEnter  <= '0;
      livePass   <= '0;
      liveAccept <= '0;
    end else if (strb.evt) begin
      liveEnter <= liveEnter + SCL_W'(1);
      if (|passBits) livePass   <= livePass + SCL_W'(1);
      if (|accBits)  liveAccept <= liveAccept + SCL_W'(1);
    end
  end

  // Atomic snapshot for the monitoring reader
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapEnter  <= '0;
      snapPass   <= '0;
      snapAccept <= '0;
    end else if (strb.snap) begin
      snapEnter  <= liveEnter;
      snapPass   <= livePass;
      snapAccept <= liveAccept;
    end
  end

endmodule

// File: rtl/trig_prescale_unit.sv
module trig_prescale_unit
  import psc_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int VAL_W    = 16,
  parameter int SCL_W    = 32,
  localparam int ADDR_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [VAL_W:0]      cfgData,
  input  logic                evtValid,
  input  logic [NUM_TRIG-1:0] passBits,
  input  logic                snapStrobe,
  output logic                outValid,
  output logic [NUM_TRIG-1:0] outBits,
  output logic                finalAccept,
  output logic [SCL_W-1:0]    liveEnter,
  output logic [SCL_W-1:0]    livePass,
  output logic [SCL_W-1:0]    liveAccept,
  output logic [SCL_W-1:0]    snapEnter,
  output logic [SCL_W-1:0]    snapPass,
  output logic [SCL_W-1:0]    snapAccept
);

  pscStrobes_t               strb;
  logic [NUM_TRIG-1:0]       modeVec;
  logic [NUM_TRIG*VAL_W-1:0] valVec;

  psc_ctrl #(.NUM_TRIG(NUM_TRIG), .VAL_W(VAL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .evtValid   (evtValid),
    .snapStrobe (snapStrobe),
    .strb       (strb),
    .modeVec    (modeVec),
    .valVec     (valVec)
  );

  psc_datapath #(.NUM_TRIG(NUM_TRIG), .VAL_W(VAL_W), .SCL_W(SCL_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .modeVec     (modeVec),
    .valVec      (valVec),
    .passBits    (passBits),
    .outValid    (outValid),
    .outBits     (outBits),
    .finalAccept (finalAccept),
    .liveEnter   (liveEnter),
    .livePass    (livePass),
    .liveAccept  (liveAccept),
    .snapEnter   (snapEnter),
    .snapPass    (snapPass),
    .snapAccept  (snapAccept)
  );

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int NUM_TRIG = 4,
  parameter int SCL_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evtValid,
  input logic [NUM_TRIG-1:0] passBits,
  input logic                snapStrobe,
  input logic                outValid,
  input logic [NUM_TRIG-1:0] outBits,
  input logic                finalAccept,
  input logic [SCL_W-1:0]    liveEnter,
  input logic [SCL_W-1:0]    livePass,
  input logic [SCL_W-1:0]    liveAccept,
  input logic [SCL_W-1:0]    snapEnter,
  input logic [SCL_W-1:0]    snapPass,
  input logic [SCL_W-1:0]    snapAccept
);

  assert_out_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> outValid);

  assert_accept_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finalAccept == (|outBits));

  assert_bits_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> ((outBits & ~$past(passBits)) == '0));

  assert_enter_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |=> (liveEnter == $past(liveEnter) + SCL_W'(1)));

  assert_accept_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finalAccept |-> (liveAccept == $past(liveAccept) + SCL_W'(1)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> (!outValid && outBits == '0 && $stable(liveEnter)
                   && $stable(livePass) && $stable(liveAccept)));

  assert_snap_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snapStrobe |=> (snapEnter == $past(liveEnter) && snapPass == $past(livePass)
                    && snapAccept == $past(liveAccept)));

endmodule

bind trig_prescale_unit psc_checker #(.NUM_TRIG(NUM_TRIG), .SCL_W(SCL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evtValid    (evtValid),
  .passBits    (passBits),
  .snapStrobe  (snapStrobe),
  .outValid    (outValid),
  .outBits     (outBits),
  .finalAccept (finalAccept),
  .liveEnter   (liveEnter),
  .livePass    (livePass),
  .liveAccept  (liveAccept),
  .snapEnter   (snapEnter),
  .snapPass    (snapPass),
  .snapAccept  (snapAccept)
);

// File: tb/trig_prescale_unit_test.sv
module trig_prescale_unit_test;

  localparam int NT   = 4;
  localparam int VW   = 16;
  localparam int SW   = 12;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [VW:0]   cfgData = '0;
  logic          evtValid = 1'b0;
  logic [NT-1:0] passBits = '0;
  logic          snapStrobe = 1'b0;
  logic          outValid;
  logic [NT-1:0] outBits;
  logic          finalAccept;
  logic [SW-1:0] liveEnter, livePass, liveAccept;
  logic [SW-1:0] snapEnter, snapPass, snapAccept;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int mMode [NT];
  int mVal  [NT];
  int mCnt  [NT];
  int mTmr  [NT];
  logic [SW-1:0] mEnter = '0, mPass = '0, mAcc = '0;
  logic [SW-1:0] sEnter = '0, sPass = '0, sAcc = '0;

  always #10 clk = ~clk;

  trig_prescale_unit #(.NUM_TRIG(NT), .VAL_W(VW), .SCL_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .evtValid(evtValid), .passBits(passBits),
    .snapStrobe(snapStrobe), .outValid(outValid), .outBits(outBits),
    .finalAccept(finalAccept), .liveEnter(liveEnter), .livePass(livePass),
    .liveAccept(liveAccept), .snapEnter(snapEnter), .snapPass(snapPass),
    .snapAccept(snapAccept)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string modeTag(input int t);
    if (mMode[t] != 0) return "R4";
    if (mVal[t] <= 1) return "R3";
    return "R2";
  endfunction

  task automatic cfgWrite(input int t, input int rate, input int v);
    evtValid = 1'b0; passBits = '0; snapStrobe = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = AW'(t);
    cfgData = {rate[0], VW'(v)};
    @(posedge clk); #2;
    cfgWrEn = 1'b0;
    mMode[t] = rate; mVal[t] = v;
    for (int i = 0; i < NT; i++) begin mCnt[i] = 0; mTmr[i] = 0; end
    check("R9 no output on write", outValid, 0);
  endtask

  task automatic step(input logic ev, input logic [NT-1:0] bits, input logic snap);
    logic [NT-1:0] acc;
    evtValid = ev; passBits = bits; snapStrobe = snap;
    @(posedge clk); #2;
    evtValid = 1'b0; passBits = '0; snapStrobe = 1'b0;
    if (snap) begin sEnter = mEnter; sPass = mPass; sAcc = mAcc; end
    acc = '0;
    for (int t = 0; t < NT; t++) begin
      bit p;
      p = ev && bits[t];
      if (mMode[t] != 0) begin
        if (p && mTmr[t] == 0) acc[t] = 1'b1;
      end else if (p) begin
        if (mVal[t] <= 1 || mCnt[t] == mVal[t] - 1) begin
          acc[t] = 1'b1; mCnt[t] = 0;
        end else mCnt[t]++;
      end
      if (acc[t] && mMode[t] != 0) mTmr[t] = mVal[t];
      else if (mTmr[t] != 0) mTmr[t]--;
    end
    if (ev) begin
      mEnter++;
      if (|bits) mPass++;
      if (|acc) mAcc++;
    end
    check(ev ? "R5 outValid" : "R10 outValid idle", outValid, ev);
    for (int t = 0; t < NT; t++)
      check(ev ? modeTag(t) : "R10 bits idle", outBits[t], acc[t]);
    check("R5 finalAccept", finalAccept, |acc);
    check("R6 liveEnter", liveEnter, mEnter);
    check("R6 livePass", livePass, mPass);
    check("R7 liveAccept", liveAccept, mAcc);
    check("R8 snapEnter", snapEnter, sEnter);
    check("R8 snapPass", snapPass, sPass);
    check("R8 snapAccept", snapAccept, sAcc);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin mMode[t] = 0; mVal[t] = 0; mCnt[t] = 0; mTmr[t] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    check("R1 outValid", outValid, 0);
    check("R1 outBits", outBits, 0);
    check("R1 finalAccept", finalAccept, 0);
    check("R1 liveEnter", liveEnter, 0);
    check("R1 liveAccept", liveAccept, 0);
    check("R1 snapEnter", snapEnter, 0);
    rst_n = 1'b1;
    // default: all triggers accept every passing event
    step(1'b1, 4'b1010, 1'b0);
    check("R3 default accept", outBits, 4'b1010);

    // directed: N=3, N=1, N=0, rate interval 4
    cfgWrite(0, 0, 3);
    cfgWrite(1, 0, 1);
    cfgWrite(2, 0, 0);
    cfgWrite(3, 1, 4);
    for (int i = 0; i < 9; i++) step(1'b1, 4'b1111, 1'b0);
    step(1'b0, 4'b1111, 1'b1);
    // R9: two events, rewrite, two more must not hit N=3
    step(1'b1, 4'b0001, 1'b0);
    step(1'b1, 4'b0001, 1'b0);
    cfgWrite(0, 0, 3);
    step(1'b1, 4'b0001, 1'b0);
    check("R9 count cleared", outBits[0], 0);
    step(1'b1, 4'b0001, 1'b0);
    check("R9 count cleared", outBits[0], 0);
    step(1'b1, 4'b0001, 1'b0);
    check("R9 third after write", outBits[0], 1);
    // R4 spacing on idle cycles
    step(1'b1, 4'b1000, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 4'b0000, 1'b0);
    step(1'b1, 4'b1000, 1'b0);
    check("R4 early event blocked", outBits[3], 0);
    step(1'b1, 4'b1000, 1'b0);
    check("R4 event at interval", outBits[3], 1);

    // random phase
    for (int r = 0; r < 40; r++) begin
      for (int t = 0; t < NT; t++) begin
        int rate;
        rate = int'($urandom % 2);
        cfgWrite(t, rate, rate != 0 ? int'($urandom % 10) : int'($urandom % 7));
      end
      for (int i = 0; i < 80; i++)
        step(($urandom % 4) != 0, NT'($urandom), ($urandom % 16) == 0);
    end

    // long run through scaler wrap
    cfgWrite(0, 0, 2);
    for (int i = 0; i < 4300; i++)
      step(1'b1, 4'b0011, (i % 500) == 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule